// File: doc/BRIEF.md
# Debounced Coin Value Accumulator

This block keeps a running money total, in cents, for coins that roll past a row of five presence sensors. A sensor line reads 1 while a coin covers it. Bigger coins cover more of the row, so the highest sensor a coin reaches tells which coin it is.

Each raw sensor line first passes through its own filter. The filter accepts a new level only after the line has held that level for `N_STABLE` clock cycles in a row, so contact bounce and short spikes are removed.

A tracker watches the five filtered lines. It treats everything from the first covered sensor until the row is clear again as one passage. During the passage it keeps the OR of every filtered pattern it has seen. When the row is clear, it reports the highest sensor index in that pattern. The accumulator then adds the matching value to the total. The total changes only at that moment, and it wraps around when it overflows.

Top module: `coin_tally`

## Requirements
- R1: Reset is active low and synchronous to the rising clock edge. One rising edge with `rst_n` low sets `total_cents` to 0, and the total stays 0 while reset is held.
- R2: A filtered sensor line takes a new level after the raw line has held that level for `N_STABLE` consecutive sampled cycles. A coin that holds sensor 0 for exactly `N_STABLE` cycles is counted.
- R3: A raw pulse shorter than `N_STABLE` cycles, on any sensor or on all of them together, never starts a passage and never changes the total.
- R4: While a passage is in progress (any filtered sensor at 1), `total_cents` keeps its value.
- R5: The highest sensor index blocked during the passage sets the coin value. Index 0 gives 1 cent, index 1 gives 5, index 2 gives 10, index 3 gives 50 and index 4 gives 100.
- R6: Suppose all raw sensors go to 0 together, starting from a settled pattern. The first rising edge that samples the zeros is edge 1. The total keeps its old value through edge `N_STABLE`+1 and shows the new value after edge `N_STABLE`+2.
- R7: `total_cents` is 16 bits wide and wraps modulo 65536 on overflow.
- R8: A spike shorter than `N_STABLE` cycles on a higher sensor, during a passage, does not change that passage's value.
- R9: Bounce on the raw lines while a coin enters adds the coin's value once, exactly as a clean passage would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sensor_in | input | 5 | Raw sensor lines; bit i at 1 means sensor i is covered |
| total_cents | output | 16 | Running total in cents, wraps modulo 65536 |

## Verification
The assertions check the following on every cycle:
- A filtered line changes only to the level the raw line had at that sampling edge.
- A completion pulse lasts one cycle, comes only after a busy cycle with a clear row, and always carries a valid sensor index.
- The total moves only on the cycle after a completion pulse, and then only by one of the five legal coin values.

Some properties only the bench scenarios can show:
- A spike of `N_STABLE`-1 cycles is rejected, while a hold of exactly `N_STABLE` cycles is accepted.
- Each coin gets the right value, including when a mid-passage spike or entry bounce is present.
- The total lands on the exact edge after the row clears.
- The total wraps after a long run of coins.

// File: rtl/coin_pkg.sv
package coin_pkg;
  localparam int unsigned NUM_SENSORS = 5;
  localparam int unsigned IDX_W       = 3;

  typedef logic [NUM_SENSORS-1:0] sense_t;
  typedef logic [IDX_W-1:0]       idx_t;

  // Index of the highest set bit; 0 when none are set.
  function automatic idx_t highest_index(input sense_t pat);
    idx_t r;
    r = '0;
    for (int i = 0; i < NUM_SENSORS; i++) begin
      if (pat[i]) r = idx_t'(i);
    end
    return r;
  endfunction

  // Coin value in cents for the highest blocked sensor index.
  function automatic logic [6:0] coin_cents(input idx_t idx);
    logic [6:0] v;
    unique case (idx)
      3'd0:    v = 7'd1;
      3'd1:    v = 7'd5;
      3'd2:    v = 7'd10;
      3'd3:    v = 7'd50;
      3'd4:    v = 7'd100;
      default: v = 7'd0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sensor_filter.sv
module sensor_filter #(
  parameter int unsigned N_STABLE = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic stable
);
  localparam int unsigned CW = (N_STABLE > 1) ? $clog2(N_STABLE) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(N_STABLE - 1);

  logic [CW-1:0] run_cnt;
  logic          differs;
  logic          accept;

  assign differs = (raw != stable);
  assign accept  = differs && (run_cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stable  <= 1'b0;
      run_cnt <= '0;
    end else if (!differs) begin
      run_cnt <= '0;
    end else if (accept) begin
      stable  <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_FILTER_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (stable != $past(stable)) |-> (stable == $past(raw))); // R2
endmodule

// File: rtl/passage_tracker.sv
module passage_tracker
  import coin_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_t deb,
  output logic   done,
  output idx_t   code,
  output logic   busy
);
  sense_t peak;
  logic   any_blocked;
  logic   start_ev;
  logic   end_ev;

  assign any_blocked = |deb;
  assign start_ev    = !busy && any_blocked;
  assign end_ev      = busy && !any_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      peak <= '0;
      done <= 1'b0;
      code <= '0;
    end else begin
      done <= 1'b0;
      if (start_ev) begin
        busy <= 1'b1;
        peak <= deb;
      end else if (end_ev) begin
        busy <= 1'b0;
        done <= 1'b1;
        code <= highest_index(peak);
        peak <= '0;
      end else if (busy) begin
        peak <= peak | deb;
      end
    end
  end

  AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(deb) == '0 && $past(busy))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (code < idx_t'(NUM_SENSORS))); // R5
endmodule

// File: rtl/total_accum.sv
module total_accum
  import coin_pkg::*;
#(
  parameter int unsigned TOTAL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               add_en,
  input  idx_t               code,
  output logic [TOTAL_W-1:0] total
);
  logic [TOTAL_W-1:0] step;
  assign step = TOTAL_W'(coin_cents(code));

  always_ff @(posedge clk) begin
    if (!rst_n) total <= '0;
    else if (add_en) total <= total + step;
  end

  AST_TOTAL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(add_en) |-> (total == $past(total))); // R4
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(add_en) |-> ((TOTAL_W'(total - $past(total)) == TOTAL_W'(1)) ||
                       (TOTAL_W'(total - $past(total)) == TOTAL_W'(5)) ||
                       (TOTAL_W'(total - $past(total)) == TOTAL_W'(10)) ||
                       (TOTAL_W'(total - $past(total)) == TOTAL_W'(50)) ||
                       (TOTAL_W'(total - $past(total)) == TOTAL_W'(100)))); // R7
endmodule

// File: rtl/coin_tally.sv
module coin_tally
  import coin_pkg::*;
#(
  parameter int unsigned N_STABLE = 7,
  parameter int unsigned TOTAL_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4:0]         sensor_in,
  output logic [TOTAL_W-1:0] total_cents
);
  sense_t deb;
  logic   coin_done;
  idx_t   coin_code;
  logic   in_passage;

  for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_filt
    sensor_filter #(.N_STABLE(N_STABLE)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (sensor_in[g]),
      .stable (deb[g])
    );
  end

  passage_tracker u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .deb   (deb),
    .done  (coin_done),
    .code  (coin_code),
    .busy  (in_passage)
  );

  total_accum #(.TOTAL_W(TOTAL_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .add_en (coin_done),
    .code   (coin_code),
    .total  (total_cents)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !$past(rst_n) |-> (total_cents == '0)); // R1
endmodule

// File: tb/sim_coin_tally.sv
`timescale 1ns/1ps
module sim_coin_tally;
  localparam int unsigned N = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sensor_in = '0;
  logic [15:0] total_cents;
  logic [15:0] expect_total = '0;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  coin_tally #(.N_STABLE(N), .TOTAL_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .sensor_in(sensor_in), .total_cents(total_cents)
  );

  localparam int TAB_LEN = 8;
  localparam int TAB_K [TAB_LEN] = '{0, 1, 2, 3, 4, 3, 0, 4};
  localparam bit TAB_B [TAB_LEN] = '{0, 0, 1, 0, 1, 1, 1, 0};
  localparam int TAB_V [TAB_LEN] = '{1, 5, 10, 50, 100, 50, 1, 100};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: total_cents=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic [4:0] pat, input int cyc);
    sensor_in = pat;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic bounce_to(input logic [4:0] from_p, input logic [4:0] to_p);
    for (int i = 0; i < 3; i++) begin
      hold(to_p, 2);
      hold(from_p, 1);
    end
    hold(to_p, N + 3);
  endtask

  // Coin reaching sensor k: cover 0..k progressively, then clear at once.
  task automatic coin(input int k, input bit bnc, input int val, input string req);
    logic [4:0] prev;
    logic [4:0] pat;
    prev = '0;
    for (int j = 0; j <= k; j++) begin
      pat = 5'((1 << (j + 1)) - 1);
      if (bnc) bounce_to(prev, pat);
      else hold(pat, N + 3);
      prev = pat;
    end
    check({req, " R4 steady during passage"}, total_cents, expect_total);
    sensor_in = '0;
    repeat (N + 1) @(negedge clk);
    check({req, " R6 not yet updated"}, total_cents, expect_total);
    @(negedge clk);
    expect_total = expect_total + 16'(val);
    check({req, " R5 value after clear"}, total_cents, expect_total);
    hold('0, 3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_total = '0;
    check("R1 reset clears", total_cents, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: total_cents=%0d expected=%0d", total_cents, expect_total);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset value", total_cents, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < TAB_LEN; t++) begin
      coin(TAB_K[t], TAB_B[t], TAB_V[t], TAB_B[t] ? "R9 bounced coin" : "R5 clean coin");
    end

    // R3: short spikes while idle
    hold(5'b10000, N - 1);
    hold('0, 3 * N);
    check("R3 idle spike sensor 4", total_cents, expect_total);
    hold(5'b11111, N - 1);
    hold('0, 3 * N);
    check("R3 idle spike all sensors", total_cents, expect_total);
    hold(5'b00001, N - 1);
    hold('0, 3 * N);
    check("R3 spike one short of N", total_cents, expect_total);

    // R2: exactly N cycles is accepted
    hold(5'b00001, N);
    hold('0, 2 * N + 4);
    expect_total = expect_total + 16'd1;
    check("R2 hold of exactly N", total_cents, expect_total);

    // R8: spike on sensor 4 during a 10-cent passage
    hold(5'b00001, N + 3);
    hold(5'b00111, N + 3);
    hold(5'b10111, N - 1);
    hold(5'b00111, N + 3);
    check("R8 steady during passage", total_cents, expect_total);
    hold('0, 2 * N + 4);
    expect_total = expect_total + 16'd10;
    check("R8 spike ignored in value", total_cents, expect_total);

    // R1: reset after activity
    do_reset();
    check("R1 total zero after release", total_cents, 16'd0);

    // R7: wrap modulo 65536
    for (int c = 0; c < 655; c++) begin
      hold(5'b11111, N + 2);
      hold('0, N + 3);
    end
    expect_total = 16'd65500;
    check("R7 before wrap", total_cents, expect_total);
    hold(5'b01111, N + 2);
    hold('0, N + 4);
    expect_total = expect_total + 16'd50;
    check("R7 wrapped total", total_cents, expect_total);
    check("R7 wrapped value is 14", total_cents, 16'd14);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule